// File: doc/BRIEF.md
# Delayed Read Lead-off Wait Controller

This block is the target-side policy logic that a PCI-to-PCI bridge uses when a master returns to collect a delayed upstream memory read. After the bridge queues such a read internally, a per-request counter records how many PCI clocks have elapsed. When the master comes back, the controller chooses between two actions. It can answer with an immediate retry. Or, if the counter has already reached a programmable threshold and the completion data is still missing, it can hold the lead-off data phase in wait states for a bounded time.

The threshold is a 6-bit field inside a 32-bit policy register image. Programming the field to zero turns the wait-state policy off. While waiting, the controller asserts TRDY# on the clock after the data turns up. If the data is still absent when the initial-latency bound is reached, the controller ends the cycle with a retry. It also emits a transfer strobe in the TRDY# clock, which tells the completion path to hand its data over. The request's counter is cleared when the read completes or when the request is discarded.

Top module: `leadoff_wait_ctrl`

## Requirements
- R1: After synchronous reset, `cfg_rdata_o` reads 0x00001200 (threshold 18), and `trdy_n_o` and `stop_n_o` are both high.
- R2: A clock with `cfg_we_i` high loads `cfg_thr_wdata_i` into the threshold. The register image then shows the threshold in bits 13:8, with every other bit reading zero.
- R3: A transaction starts on the first clock edge at which the controller is idle and samples `frame_n_i` low. If `data_avail_i` is high at that edge, TRDY# is low in the next clock (latency 1).
- R4: With a threshold of zero, an absent-data return is always retried with latency 1, however long the request has been queued.
- R5: If the return edge comes fewer than threshold clocks after the enqueue edge and data is absent, STOP# is low with latency 1 and TRDY# stays high.
- R6: If the return edge comes at least threshold clocks after the enqueue edge and data is absent, both TRDY# and STOP# stay high. When data is first sampled j clocks after the start edge (1 ≤ j ≤ 15), TRDY# goes low with latency j+1.
- R7: If data has not been sampled by the 15th clock after the start edge, STOP# goes low without TRDY# at latency 16, measured from FRAME# sampled low.
- R8: TRDY# and STOP# are never low together. Each is low for exactly one clock per transaction. A new transaction needs FRAME# to be sampled high first.
- R9: The elapsed-time counter restarts on `enq_i` and stops at the threshold value. It is cleared by `discard_i` or by a completed TRDY# transfer, so a later absent-data return without a fresh enqueue gets a retry at latency 1.
- R10: `data_xfer_o` is high exactly in the clocks where TRDY# is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we_i | input | 1 | Threshold write strobe |
| cfg_thr_wdata_i | input | 6 | New threshold value, in PCI clocks |
| cfg_rdata_o | output | 32 | Policy register image, threshold at bits 13:8 |
| enq_i | input | 1 | Pulse: delayed read was queued internally |
| discard_i | input | 1 | Pulse: delayed request was discarded |
| data_avail_i | input | 1 | Completion data for the request is present |
| frame_n_i | input | 1 | FRAME#, active low |
| trdy_n_o | output | 1 | TRDY#, active low |
| stop_n_o | output | 1 | STOP#, active low |
| data_xfer_o | output | 1 | Strobe telling the completion path to deliver data |

## Verification
The bench targets the exact threshold edge: a return one clock before the threshold must retry at once, and a return exactly at the threshold must wait. A design with an off-by-one counter would swap those two outcomes. It also probes the 16-clock bound from both sides. If data is sampled on the 15th clock, the transfer must happen at latency 16. If data only appears one clock later, the cycle must be retried. A misplaced bound would either retry a read that could have been served or stretch initial latency past 16. Further cases cover a zero threshold after a long queue time and a return after completion or discard with no new enqueue. A design that failed to disable the policy, or that failed to clear the counter, would stall a cycle that should be retried.

// File: rtl/lw_pkg.sv
package lw_pkg;

    localparam int unsigned LW_REG_W     = 32;
    localparam int unsigned LW_THR_LSB   = 8;
    localparam int unsigned LW_THR_W     = 6;
    localparam logic [31:0] LW_REG_RESET = 32'h0000_1200;
    localparam int unsigned LW_WAIT_MAX  = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_XFER,
        ST_RETRY,
        ST_DRAIN
    } lw_state_e;

    // Active-high view of the target response for one clock
    typedef struct packed {
        logic trdy;
        logic stop;
    } lw_resp_t;

    function automatic logic lat_reached(input logic pend,
                                         input logic [LW_THR_W-1:0] cnt,
                                         input logic [LW_THR_W-1:0] thr);
        return pend && (thr != '0) && (cnt >= thr);
    endfunction

endpackage

// File: rtl/lw_policy_reg.sv
module lw_policy_reg
    import lw_pkg::*;
#(
    parameter int unsigned REG_W     = LW_REG_W,
    parameter int unsigned THR_LSB   = LW_THR_LSB,
    parameter int unsigned THR_W     = LW_THR_W,
    parameter logic [31:0] RESET_VAL = LW_REG_RESET
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we_i,
    input  logic [THR_W-1:0] wdata_i,
    output logic [THR_W-1:0] thr_o,
    output logic [REG_W-1:0] rdata_o
);
    localparam logic [THR_W-1:0] THR_RST = RESET_VAL[THR_LSB +: THR_W];

    logic [THR_W-1:0] thr_q;

    always_ff @(posedge clk) begin
        if (rst)       thr_q <= THR_RST;
        else if (we_i) thr_q <= wdata_i;
    end

    always_comb begin
        rdata_o = '0;
        rdata_o[THR_LSB +: THR_W] = thr_q;
    end

    assign thr_o = thr_q;

    // R2: a write is visible on the next clock
    p_field_write_r2: assert property (@(posedge clk) disable iff (rst)
        we_i |=> (thr_o == $past(wdata_i)));

endmodule

// File: rtl/lw_lat_counter.sv
module lw_lat_counter
    import lw_pkg::*;
#(
    parameter int unsigned CNT_W = LW_THR_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enq_i,
    input  logic             clear_i,
    input  logic [CNT_W-1:0] thr_i,
    output logic             reached_o
);
    logic             pend_q;
    logic [CNT_W-1:0] cnt_q;

    // Counting starts at one so the value equals clocks since the enqueue edge
    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            pend_q <= 1'b0;
            cnt_q  <= '0;
        end else if (enq_i) begin
            pend_q <= 1'b1;
            cnt_q  <= CNT_W'(1);
        end else if (pend_q && (cnt_q < thr_i)) begin
            cnt_q  <= cnt_q + CNT_W'(1);
        end
    end

    assign reached_o = lat_reached(pend_q, cnt_q, thr_i);

    // R9: counter holds once it has reached the threshold
    p_saturate_r9: assert property (@(posedge clk) disable iff (rst)
        (pend_q && !enq_i && !clear_i && (cnt_q >= thr_i)) |=> $stable(cnt_q));

    // R9: a clear leaves no pending request behind
    p_clear_r9: assert property (@(posedge clk) disable iff (rst)
        clear_i |=> !reached_o);

endmodule

// File: rtl/lw_target_fsm.sv
module lw_target_fsm
    import lw_pkg::*;
#(
    parameter int unsigned WAIT_LIMIT = LW_WAIT_MAX
) (
    input  logic clk,
    input  logic rst,
    input  logic frame_n_i,
    input  logic data_avail_i,
    input  logic reached_i,
    output logic trdy_n_o,
    output logic stop_n_o,
    output logic xfer_o,
    output logic done_o
);
    localparam int unsigned          WCNT_W   = $clog2(WAIT_LIMIT + 1);
    localparam logic [WCNT_W-1:0]    WCNT_END = WCNT_W'(WAIT_LIMIT - 1);

    lw_state_e         state_q, state_d;
    logic [WCNT_W-1:0] wcnt_q, wcnt_d;
    lw_resp_t          resp;

    always_comb begin
        state_d = state_q;
        wcnt_d  = wcnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!frame_n_i) begin
                    if (data_avail_i)   state_d = ST_XFER;
                    else if (reached_i) begin
                        state_d = ST_WAIT;
                        wcnt_d  = WCNT_W'(1);
                    end else            state_d = ST_RETRY;
                end
            end
            ST_WAIT: begin
                if (data_avail_i)            state_d = ST_XFER;
                else if (wcnt_q == WCNT_END) state_d = ST_RETRY;
                else                         wcnt_d  = wcnt_q + WCNT_W'(1);
            end
            ST_XFER, ST_RETRY: state_d = ST_DRAIN;
            ST_DRAIN: if (frame_n_i) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            wcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            wcnt_q  <= wcnt_d;
        end
    end

    always_comb begin
        resp.trdy = (state_q == ST_XFER);
        resp.stop = (state_q == ST_RETRY);
    end

    assign trdy_n_o = !resp.trdy;
    assign stop_n_o = !resp.stop;
    assign xfer_o   = resp.trdy;
    assign done_o   = resp.trdy;

    // R3: data present at the start edge gives TRDY# next clock
    p_immediate_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && !frame_n_i && data_avail_i) |=> !trdy_n_o);

    // R5: early absent-data return is retried at once
    p_early_retry_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && !frame_n_i && !data_avail_i && !reached_i) |=> !stop_n_o);

    // R6: data seen while waiting yields TRDY# next clock
    p_data_next_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT && data_avail_i) |=> !trdy_n_o);

    // R7: the wait window never runs past its bound
    p_bound_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT) |-> (wcnt_q < WCNT_W'(WAIT_LIMIT)));

    // R8: each response lasts one clock
    p_trdy_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        !trdy_n_o |=> trdy_n_o);
    p_stop_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        !stop_n_o |=> stop_n_o);

endmodule

// File: rtl/leadoff_wait_ctrl.sv
module leadoff_wait_ctrl
    import lw_pkg::*;
#(
    parameter int unsigned REG_W      = LW_REG_W,
    parameter int unsigned THR_LSB    = LW_THR_LSB,
    parameter int unsigned THR_W      = LW_THR_W,
    parameter logic [31:0] RESET_VAL  = LW_REG_RESET,
    parameter int unsigned WAIT_LIMIT = LW_WAIT_MAX
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we_i,
    input  logic [THR_W-1:0] cfg_thr_wdata_i,
    output logic [REG_W-1:0] cfg_rdata_o,
    input  logic             enq_i,
    input  logic             discard_i,
    input  logic             data_avail_i,
    input  logic             frame_n_i,
    output logic             trdy_n_o,
    output logic             stop_n_o,
    output logic             data_xfer_o
);
    logic [THR_W-1:0] thr;
    logic             reached;
    logic             done;
    logic             clear;

    lw_policy_reg #(
        .REG_W     (REG_W),
        .THR_LSB   (THR_LSB),
        .THR_W     (THR_W),
        .RESET_VAL (RESET_VAL)
    ) u_reg (
        .clk     (clk),
        .rst     (rst),
        .we_i    (cfg_we_i),
        .wdata_i (cfg_thr_wdata_i),
        .thr_o   (thr),
        .rdata_o (cfg_rdata_o)
    );

    assign clear = discard_i | done;

    lw_lat_counter #(
        .CNT_W (THR_W)
    ) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .enq_i     (enq_i),
        .clear_i   (clear),
        .thr_i     (thr),
        .reached_o (reached)
    );

    lw_target_fsm #(
        .WAIT_LIMIT (WAIT_LIMIT)
    ) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .frame_n_i    (frame_n_i),
        .data_avail_i (data_avail_i),
        .reached_i    (reached),
        .trdy_n_o     (trdy_n_o),
        .stop_n_o     (stop_n_o),
        .xfer_o       (data_xfer_o),
        .done_o       (done)
    );

    // R4: a zero threshold never lets the controller hold off the cycle
    p_disabled_r4: assert property (@(posedge clk) disable iff (rst)
        (thr == '0) |-> !reached);

endmodule

// File: tb/leadoff_wait_ctrl_tb_top.sv
`timescale 1ns/1ps
module leadoff_wait_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [5:0]  cfg_wd;
    logic [31:0] cfg_rd;
    logic        enq, discard, data, frame_n;
    logic        trdy_n, stop_n, xfer;

    int checks   = 0;
    int failures = 0;

    always #4 clk = ~clk;

    leadoff_wait_ctrl dut_i (
        .clk             (clk),
        .rst             (rst),
        .cfg_we_i        (cfg_we),
        .cfg_thr_wdata_i (cfg_wd),
        .cfg_rdata_o     (cfg_rd),
        .enq_i           (enq),
        .discard_i       (discard),
        .data_avail_i    (data),
        .frame_n_i       (frame_n),
        .trdy_n_o        (trdy_n),
        .stop_n_o        (stop_n),
        .data_xfer_o     (xfer)
    );

    // ---------------- behavioural reference ----------------
    int m_thr, m_elapsed, m_phase, m_waited;
    bit m_pend, m_trdy, m_stop;

    always @(posedge clk) begin
        if (rst) begin
            m_thr = 18; m_pend = 0; m_elapsed = 0; m_phase = 0;
            m_waited = 0; m_trdy = 0; m_stop = 0;
        end else begin
            bit hit, was_trdy, nt, ns;
            hit = m_pend && (m_thr != 0) && (m_elapsed >= m_thr);
            was_trdy = m_trdy;
            nt = 0; ns = 0;
            if (m_phase == 0) begin
                if (!frame_n) begin
                    if (data)     nt = 1;
                    else if (hit) begin m_phase = 1; m_waited = 1; end
                    else          ns = 1;
                end
            end else if (m_phase == 1) begin
                if (data)                nt = 1;
                else if (m_waited == 15) ns = 1;
                else                     m_waited++;
            end else if (m_phase == 2) begin
                m_phase = 3;
            end else if (frame_n) begin
                m_phase = 0;
            end
            if (nt || ns) m_phase = 2;
            if (discard || was_trdy) begin m_pend = 0; m_elapsed = 0; end
            else if (enq)            begin m_pend = 1; m_elapsed = 1; end
            else if (m_pend)         m_elapsed++;
            if (cfg_we) m_thr = cfg_wd;
            m_trdy = nt; m_stop = ns;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            checks++;
            if (trdy_n !== !m_trdy) begin
                failures++;
                $display("FAIL R6 per-clock trdy_n act=%0b exp=%0b t=%0t", trdy_n, !m_trdy, $time);
            end
            if (stop_n !== !m_stop) begin
                failures++;
                $display("FAIL R7 per-clock stop_n act=%0b exp=%0b t=%0t", stop_n, !m_stop, $time);
            end
            if (xfer !== m_trdy) begin
                failures++;
                $display("FAIL R10 per-clock xfer act=%0b exp=%0b t=%0t", xfer, m_trdy, $time);
            end
            if (cfg_rd !== {18'b0, m_thr[5:0], 8'b0}) begin
                failures++;
                $display("FAIL R2 per-clock rdata act=%h exp=%h", cfg_rd, {18'b0, m_thr[5:0], 8'b0});
            end
            if (!trdy_n && !stop_n) begin
                failures++;
                $display("FAIL R8 both low act=00 exp=not both");
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_enq();
        enq = 1; @(negedge clk); enq = 0;
    endtask

    task automatic pulse_discard();
        discard = 1; @(negedge clk); discard = 0;
    endtask

    task automatic write_thr(input int v);
        cfg_we = 1; cfg_wd = 6'(v); @(negedge clk); cfg_we = 0;
    endtask

    // d: clock after the start edge at which data is first sampled (-1: never)
    task automatic do_read(input int d, input bit exp_trdy, input int exp_lat, input string tag);
        int lat = 0;
        int got = 0;
        frame_n = 0;
        if (d == 0) data = 1;
        while (got == 0 && lat < 40) begin
            @(negedge clk);
            lat++;
            if (!trdy_n)      got = 1;
            else if (!stop_n) got = 2;
            else if (lat == d) data = 1;
        end
        checks++;
        if (got != (exp_trdy ? 1 : 2) || lat != exp_lat) begin
            failures++;
            $display("FAIL %s act=%s@%0d exp=%s@%0d", tag,
                     got == 1 ? "TRDY" : (got == 2 ? "STOP" : "none"), lat,
                     exp_trdy ? "TRDY" : "STOP", exp_lat);
        end
        frame_n = 1; data = 0;
        idle(3);
    endtask

    // ---------------- main sequence ----------------
    initial begin
        rst = 1; cfg_we = 0; cfg_wd = 0; enq = 0; discard = 0; data = 0; frame_n = 1;
        idle(3);
        checks++;
        if (cfg_rd !== 32'h0000_1200 || trdy_n !== 1'b1 || stop_n !== 1'b1) begin
            failures++;
            $display("FAIL R1 reset act=%h/%0b/%0b exp=00001200/1/1", cfg_rd, trdy_n, stop_n);
        end
        rst = 0;
        idle(2);

        // R3: data already present
        pulse_enq(); idle(2);
        do_read(0, 1, 1, "R3 immediate transfer");

        // R5 then R6 on the same request, then R9 cleared by completion
        pulse_enq(); idle(3);
        do_read(-1, 0, 1, "R5 early return retried");
        idle(20);
        do_read(7, 1, 8, "R6 data inside window");
        do_read(-1, 0, 1, "R9 cleared by completion");

        // R7: bound and its edges
        pulse_enq(); idle(25);
        do_read(-1, 0, 16, "R7 data never arrives");
        do_read(15, 1, 16, "R7 data on last clock");
        pulse_enq(); idle(25);
        do_read(16, 0, 16, "R7 data one clock late");

        // R9: discard clears the request
        pulse_discard();
        pulse_enq(); idle(25);
        pulse_discard();
        do_read(-1, 0, 1, "R9 cleared by discard");

        // R4 and R2: zero threshold
        write_thr(0);
        checks++;
        if (cfg_rd !== 32'h0) begin
            failures++;
            $display("FAIL R2 zero write act=%h exp=00000000", cfg_rd);
        end
        pulse_enq(); idle(40);
        do_read(-1, 0, 1, "R4 disabled policy retries");
        do_read(0, 1, 1, "R4 disabled policy still transfers");

        write_thr(63);
        checks++;
        if (cfg_rd !== 32'h0000_3F00) begin
            failures++;
            $display("FAIL R2 max write act=%h exp=00003f00", cfg_rd);
        end

        // R5/R6 threshold edge with threshold 4
        write_thr(4);
        pulse_enq(); idle(2);
        do_read(-1, 0, 1, "R5 one clock before threshold");
        pulse_discard();
        pulse_enq(); idle(3);
        do_read(-1, 0, 16, "R6 exactly at threshold waits");
        pulse_discard();

        idle(4);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog act=running exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule